// File: doc/BRIEF.md
# Two-Port Double-Data-Rate Burst SRAM

This block is a synthesizable behavioural model of a synchronous static memory that has two independent ports. One port only reads and the other only writes. Each port has its own active-low select and its own address bus. Every access moves a burst of two data words. The model is clocked by a main clock and its complement. Write data is taken in on the rising edge of each of the two clocks. Read data is driven out on both halves of the main clock after a fixed pipeline delay.

Each data word is split into bytes. Each byte has its own active-low write enable, and these enables are sampled together with each word of the burst, so the two words of one burst can carry different masks. A read and a write may both start on the same main clock edge. When they target the same burst, the read returns the freshly written bytes. The depth is a parameter and is kept small so that the model simulates quickly.

Top module: `qdr_sram`

## Requirements
- R1: While reset is asserted, and after it is released until a read completes, `q_valid` is low.
- R2: A read started by `rd_sel_n` low on main clock edge n returns the first word while the clock is low after the complementary edge at n+1.5. It returns the second word while the clock is high after edge n+2. `q_valid` is high in both of these half cycles.
- R3: Burst address A holds two words: word 0 is the first word of the burst and word 1 is the second. The word index never carries into A, so the highest burst address and burst 0 are fully independent.
- R4: `bw_n[i]` low writes byte i, which is bits [9i+8:9i] of the word. `bw_n` is sampled with each word, so word 0 and word 1 of a burst take separate masks. Bytes whose enable is high keep their old value.
- R5: With `wr_sel_n` high on a main clock edge, the data and byte enables presented in the data phase that would follow change no stored byte.
- R6: A read and a write started on the same main clock edge to different bursts both complete correctly.
- R7: A read started on the same edge as a write to the same burst, or on any later edge, returns the written bytes where their enables were low and the previous contents elsewhere.
- R8: In a half cycle where no read data is due, `q_valid` is low.
- R9: Reads started on consecutive main clock edges give an unbroken stream of two words per cycle.
- R10: Writes started on consecutive main clock edges are all stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock; addresses, selects and the first write word are sampled on its rising edge |
| clk_n | input | 1 | Complement of the main clock; the second write word is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the control pipeline |
| rd_sel_n | input | 1 | Active-low read start |
| rd_addr | input | ADDR_W | Burst address for the read |
| wr_sel_n | input | 1 | Active-low write start |
| wr_addr | input | ADDR_W | Burst address for the write |
| d | input | DATA_W | Write data word |
| bw_n | input | DATA_W/BYTE_W | Active-low byte write enables for the word on `d` |
| q | output | DATA_W | Read data: word 0 while the clock is low, word 1 while it is high |
| q_valid | output | 1 | High while `q` carries read data |

## Verification
A wrong pipeline stage in this design shows at the ports within two main clock cycles. If it drops or duplicates a stage, `q_valid` rises half a cycle early or late, or it rises without a matching read. A fault in the forwarding path only shows when a read starts on the same edge as a write to the same burst. A masked byte then comes back wrong in the very next data phase, so the bench runs that collision with mixed masks. A faulty write mask or word index corrupts the stored array. That error stays hidden until the affected burst is read back, so every write is compared against a reference array when it is read.

// File: rtl/qdr_pkg.sv
package qdr_pkg;
    localparam int DEF_DATA_W = 18;   // word width
    localparam int DEF_BYTE_W = 9;    // width covered by one byte enable
    localparam int DEF_ADDR_W = 6;    // burst address width (64 bursts)
    localparam int BURST_LEN  = 2;    // words per access
endpackage

// File: rtl/qdr_array.sv
// Burst-wide storage: one entry per burst address, byte-lane write enables.
module qdr_array #(
    parameter int LANE_W = 9,
    parameter int LANES  = 4,
    parameter int ADDR_W = 6
) (
    input  logic                      clk,
    input  logic                      we,
    input  logic [ADDR_W-1:0]         waddr,
    input  logic [LANES-1:0]          wbe,
    input  logic [LANES*LANE_W-1:0]   wdata,
    input  logic [ADDR_W-1:0]         raddr,
    output logic [LANES*LANE_W-1:0]   rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we && wbe[l]) begin
                mem[waddr] <= wdata[l*LANE_W +: LANE_W];
            end
        end

        assign rdata[l*LANE_W +: LANE_W] = mem[raddr];
    end
endmodule

// File: rtl/qdr_ddr_out.sv
// Output stage: high half of clk shows the rise-edge register, low half the fall-edge one.
module qdr_ddr_out #(
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic [DATA_W-1:0] hi_data,
    input  logic              hi_vld,
    input  logic [DATA_W-1:0] lo_data,
    input  logic              lo_vld,
    output logic [DATA_W-1:0] q,
    output logic              q_valid
);
    always_comb begin
        if (clk) begin
            q       = hi_data;
            q_valid = hi_vld;
        end else begin
            q       = lo_data;
            q_valid = lo_vld;
        end
    end
endmodule

// File: rtl/qdr_sram.sv
module qdr_sram #(
    parameter int DATA_W = qdr_pkg::DEF_DATA_W,
    parameter int BYTE_W = qdr_pkg::DEF_BYTE_W,
    parameter int ADDR_W = qdr_pkg::DEF_ADDR_W
) (
    input  logic                     clk,
    input  logic                     clk_n,
    input  logic                     rst_n,
    input  logic                     rd_sel_n,
    input  logic [ADDR_W-1:0]        rd_addr,
    input  logic                     wr_sel_n,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        d,
    input  logic [DATA_W/BYTE_W-1:0] bw_n,
    output logic [DATA_W-1:0]        q,
    output logic                     q_valid
);
    localparam int NBYTE = DATA_W / BYTE_W;
    localparam int LANES = NBYTE * qdr_pkg::BURST_LEN;

    // State advanced on the main clock edge
    typedef struct packed {
        logic              rv0;   // read latched this cycle
        logic [ADDR_W-1:0] ra0;
        logic              rv1;   // read in its data phase
        logic [ADDR_W-1:0] ra1;
        logic              wv0;   // write latched this cycle
        logic [ADDR_W-1:0] wa0;
        logic              wv1;   // write in its data phase, commits next edge
        logic [ADDR_W-1:0] wa1;
        logic [DATA_W-1:0] wd0;   // first write word
        logic [NBYTE-1:0]  wbe0;  // its active-high byte enables
        logic [DATA_W-1:0] qr;    // second read word
        logic              vr;
    } kst_t;

    // State advanced on the complementary clock edge
    typedef struct packed {
        logic [DATA_W-1:0] wd1;   // second write word
        logic [NBYTE-1:0]  wbe1;
        logic [DATA_W-1:0] qf;    // first read word
        logic              vf;
    } fst_t;

    kst_t k_q, k_d;
    fst_t f_q, f_d;

    logic [LANES*BYTE_W-1:0] arr_rdata;
    logic [DATA_W-1:0]       arr_w0, arr_w1;
    logic                    rd_hit;

    assign arr_w0 = arr_rdata[DATA_W-1:0];
    assign arr_w1 = arr_rdata[2*DATA_W-1:DATA_W];
    assign rd_hit = k_q.wv1 && (k_q.wa1 == k_q.ra1);

    function automatic logic [DATA_W-1:0] merge_bytes(
        input logic [DATA_W-1:0] old_w,
        input logic [DATA_W-1:0] new_w,
        input logic [NBYTE-1:0]  en
    );
        logic [DATA_W-1:0] r;
        r = old_w;
        for (int i = 0; i < NBYTE; i++) begin
            if (en[i]) r[i*BYTE_W +: BYTE_W] = new_w[i*BYTE_W +: BYTE_W];
        end
        return r;
    endfunction

    // Main-edge next state
    always_comb begin
        k_d     = k_q;
        k_d.rv0 = !rd_sel_n;
        if (!rd_sel_n) k_d.ra0 = rd_addr;
        k_d.rv1 = k_q.rv0;
        k_d.ra1 = k_q.ra0;
        k_d.wv0 = !wr_sel_n;
        if (!wr_sel_n) k_d.wa0 = wr_addr;
        k_d.wv1 = k_q.wv0;
        k_d.wa1 = k_q.wa0;
        if (k_q.wv0) begin
            k_d.wd0  = d;
            k_d.wbe0 = ~bw_n;
        end
        k_d.vr = k_q.rv1;
        if (k_q.rv1) begin
            k_d.qr = rd_hit ? merge_bytes(arr_w1, f_q.wd1, f_q.wbe1) : arr_w1;
        end
    end

    // Complementary-edge next state
    always_comb begin
        f_d = f_q;
        if (k_q.wv1) begin
            f_d.wd1  = d;
            f_d.wbe1 = ~bw_n;
        end
        f_d.vf = k_q.rv1;
        if (k_q.rv1) begin
            f_d.qf = rd_hit ? merge_bytes(arr_w0, k_q.wd0, k_q.wbe0) : arr_w0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) k_q <= '0;
        else        k_q <= k_d;
    end

    always_ff @(posedge clk_n or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    qdr_array #(
        .LANE_W (BYTE_W),
        .LANES  (LANES),
        .ADDR_W (ADDR_W)
    ) i_array (
        .clk    (clk),
        .we     (k_q.wv1),
        .waddr  (k_q.wa1),
        .wbe    ({f_q.wbe1, k_q.wbe0}),
        .wdata  ({f_q.wd1, k_q.wd0}),
        .raddr  (k_q.ra1),
        .rdata  (arr_rdata)
    );

    qdr_ddr_out #(
        .DATA_W (DATA_W)
    ) i_out (
        .clk     (clk),
        .hi_data (k_q.qr),
        .hi_vld  (k_q.vr),
        .lo_data (f_q.qf),
        .lo_vld  (f_q.vf),
        .q       (q),
        .q_valid (q_valid)
    );

    AST_RD_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_sel_n |-> ##3 k_q.vr);                                   // R2
    AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_sel_n |-> ##3 !k_q.vr);                                   // R8
    AST_BURST_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.vf |=> k_q.vr);                                          // R3
    AST_WR_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_sel_n |-> ##2 k_q.wv1);                                  // R10
    AST_WR_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sel_n |-> ##2 !k_q.wv1);                                  // R5
endmodule

// File: tb/test_qdr_sram.sv
module test_qdr_sram;
    localparam int DW = 18;
    localparam int AW = 6;
    localparam int NB = 2;

    logic          clk = 1'b0;
    logic          clk_n;
    logic          rst_n = 1'b0;
    logic          rd_sel_n = 1'b1;
    logic [AW-1:0] rd_addr = '0;
    logic          wr_sel_n = 1'b1;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] d = '0;
    logic [NB-1:0] bw_n = '1;
    logic [DW-1:0] q;
    logic          q_valid;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;   // 125 MHz
    assign clk_n = ~clk;

    qdr_sram i_qdr_sram (
        .clk(clk), .clk_n(clk_n), .rst_n(rst_n),
        .rd_sel_n(rd_sel_n), .rd_addr(rd_addr),
        .wr_sel_n(wr_sel_n), .wr_addr(wr_addr),
        .d(d), .bw_n(bw_n), .q(q), .q_valid(q_valid)
    );

    typedef struct packed {
        logic          v;
        logic [DW-1:0] d0;
        logic [NB-1:0] b0;
        logic [DW-1:0] d1;
        logic [NB-1:0] b1;
    } wrec_t;

    typedef struct packed {
        logic          v;
        logic [DW-1:0] e0;
        logic [DW-1:0] e1;
    } rrec_t;

    logic [DW-1:0] ref_mem [2**(AW+1)];
    wrec_t w_p1 = '0, w_p2 = '0;
    rrec_t r_p1 = '0, r_p2 = '0;
    string t_p1 = "R8", t_p2 = "R8";

    task automatic chk_bit(string tag, string what, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    task automatic chk_word(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic ref_write(logic [AW-1:0] a, logic w, logic [DW-1:0] val, logic [NB-1:0] b);
        for (int i = 0; i < NB; i++) begin
            if (!b[i]) ref_mem[{a, w}][i*9 +: 9] = val[i*9 +: 9];
        end
    endtask

    task automatic check_slot(logic hi);
        if (r_p2.v) begin
            chk_bit(t_p2, hi ? "word1 valid" : "word0 valid", q_valid, 1'b1);
            chk_word(t_p2, hi ? "word1 data" : "word0 data", q, hi ? r_p2.e1 : r_p2.e0);
        end else begin
            chk_bit("R8", "idle valid", q_valid, 1'b0);
        end
    endtask

    // One main-clock cycle; starts and ends 2 ns after a rising clk edge.
    task automatic tick(logic rv, logic [AW-1:0] ra, logic wv, logic [AW-1:0] wa,
                        logic [DW-1:0] w0, logic [NB-1:0] b0,
                        logic [DW-1:0] w1, logic [NB-1:0] b1, string tag);
        wrec_t nw;
        rrec_t nr;
        nw = '{v: wv, d0: w0, b0: b0, d1: w1, b1: b1};
        rd_sel_n = !rv; rd_addr = ra;
        wr_sel_n = !wv; wr_addr = wa;
        d    = w_p2.v ? w_p2.d1 : DW'($urandom);
        bw_n = w_p2.v ? w_p2.b1 : NB'($urandom);
        if (wv) begin
            ref_write(wa, 1'b0, w0, b0);
            ref_write(wa, 1'b1, w1, b1);
        end
        nr = '{v: rv, e0: ref_mem[{ra, 1'b0}], e1: ref_mem[{ra, 1'b1}]};
        #4;
        check_slot(1'b0);
        d    = w_p1.v ? w_p1.d0 : DW'($urandom);
        bw_n = w_p1.v ? w_p1.b0 : NB'($urandom);
        #4;
        check_slot(1'b1);
        w_p2 = w_p1; w_p1 = nw;
        r_p2 = r_p1; r_p1 = nr;
        t_p2 = t_p1; t_p1 = tag;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick(0, '0, 0, '0, '0, '1, '0, '1, "R8");
    endtask

    task automatic wr(logic [AW-1:0] a, logic [DW-1:0] w0, logic [NB-1:0] b0,
                      logic [DW-1:0] w1, logic [NB-1:0] b1);
        tick(0, '0, 1, a, w0, b0, w1, b1, "R8");
    endtask

    task automatic rd(logic [AW-1:0] a, string tag);
        tick(1, a, 0, '0, '0, '1, '0, '1, tag);
    endtask

    task automatic t_reset();
        chk_bit("R1", "valid in reset", q_valid, 1'b0);
        #4;
        chk_bit("R1", "valid in reset low phase", q_valid, 1'b0);
        @(posedge clk); #2;
        rst_n = 1'b1;
        chk_bit("R1", "valid after release", q_valid, 1'b0);
        idle(2);
    endtask

    task automatic t_fill();
        for (int a = 0; a < 2**AW; a++) begin
            wr(AW'(a), DW'(a * 7 + 1), '0, DW'(a * 13 + 5), '0);
        end
        idle(2);
    endtask

    task automatic t_basic();
        wr(6'd5, 18'h1_2345, 2'b00, 18'h2_6789, 2'b00);
        rd(6'd5, "R2");
        idle(2);
    endtask

    task automatic t_order();
        wr(6'd63, 18'h3_0F0F, 2'b00, 18'h0_F0F0, 2'b00);
        wr(6'd0,  18'h1_1111, 2'b00, 18'h2_2222, 2'b00);
        rd(6'd63, "R3");
        rd(6'd0,  "R3");
        rd(6'd62, "R3");
        idle(2);
    endtask

    task automatic t_mask();
        wr(6'd10, 18'h0_0000, 2'b00, 18'h0_0000, 2'b00);
        wr(6'd10, 18'h3_FFFF, 2'b10, 18'h3_FFFF, 2'b01);
        rd(6'd10, "R4");
        wr(6'd10, 18'h2_AAAA, 2'b11, 18'h1_5555, 2'b00);
        rd(6'd10, "R4");
        idle(2);
    endtask

    task automatic t_ignore();
        wr(6'd20, 18'h0_ABCD, 2'b00, 18'h1_BCDE, 2'b00);
        for (int i = 0; i < 3; i++) tick(0, '0, 0, 6'd20, '0, '0, '0, '0, "R5");
        rd(6'd20, "R5");
        idle(2);
    endtask

    task automatic t_same_cycle();
        tick(1, 6'd5, 1, 6'd30, 18'h2_0303, 2'b00, 18'h1_3030, 2'b00, "R6");
        rd(6'd30, "R6");
        idle(2);
    endtask

    task automatic t_overlap();
        wr(6'd40, 18'h3_FFFF, 2'b00, 18'h3_FFFF, 2'b00);
        tick(1, 6'd40, 1, 6'd40, 18'h0_0000, 2'b01, 18'h0_0000, 2'b10, "R7");
        tick(1, 6'd40, 1, 6'd41, 18'h1_2121, 2'b00, 18'h0_4141, 2'b00, "R7");
        wr(6'd41, 18'h2_5555, 2'b10, 18'h1_6666, 2'b01);
        rd(6'd41, "R7");
        idle(2);
    endtask

    task automatic t_stream();
        for (int i = 0; i < 4; i++) begin
            wr(AW'(50 + i), DW'(18'h1_0000 + i), '0, DW'(18'h2_0000 + i), '0);
        end
        for (int i = 0; i < 4; i++) rd(AW'(50 + i), "R10");
        for (int i = 0; i < 4; i++) rd(AW'(53 - i), "R9");
        idle(2);
        for (int i = 0; i < 200; i++) begin
            tick($urandom_range(0, 1) == 1, AW'($urandom_range(0, 7)),
                 $urandom_range(0, 1) == 1, AW'($urandom_range(0, 7)),
                 DW'($urandom), NB'($urandom), DW'($urandom), NB'($urandom), "R9");
        end
        idle(2);
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL R2 watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        t_reset();
        t_fill();
        t_basic();
        t_order();
        t_mask();
        t_ignore();
        t_same_cycle();
        t_overlap();
        idle(3);
        t_stream();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule